// File: doc/BRIEF.md
# Multi-Mode Host Bus Register Slave

This block lets a host processor read and write a small bank of 8-bit registers over a 15-bit address bus and an 8-bit data bus. The same few control pins serve three bus styles. A static mode input picks the style, and the block captures that input only while reset is held. In the Intel-style asynchronous mode, a separate address-latch pulse, a read strobe and a write strobe run each access. In the Motorola-style asynchronous mode, an address strobe, a data strobe and a read/write direction level run each access. In the synchronous mode, every access is decided on a rising edge of the block clock, which is also the processor clock.

Every asynchronous strobe goes through a two-flop synchronizer, and the block detects its edges in the clock domain. The data bus is split into `data_i`, `data_o` and an output enable `data_oe`. The pad ring combines them into the tri-state pins, and `data_oe` low means high impedance. The address bus and the data bus are not handshaken streams, so there is no valid/ready pair and no back-pressure. The host must hold the address, the data and each strobe level for at least four clock cycles so that the synchronized edges see stable values.

Top module: `host_bus_slave`

## Requirements
- R1: `mode_sel` is sampled on every clock edge while `rst_n` is low. The encodings are 2'b00 Intel-style, 2'b01 Motorola-style, and 2'b10 or 2'b11 synchronous. A change of `mode_sel` after reset is released has no effect.
- R2: In Intel-style mode, `ale_as` is active high. The address on `addr_i` is captured when the synchronized `ale_as` falls.
- R3: In Intel-style mode, `strb_n` low (read strobe) together with `cs_n` low drives the register at the latched address on `data_o` with `data_oe` high. After `strb_n` returns high, `data_oe` goes low.
- R4: In Intel-style mode, `rw_ctl` is an active-low write strobe. Its synchronized rising edge stores `data_i` into the latched address, provided `cs_n` was low while the strobe was low.
- R5: In Motorola-style mode, `ale_as` is an active-low address strobe. The address is captured when the synchronized `ale_as` rises.
- R6: In Motorola-style mode, `strb_n` is the data strobe. While it is low with `cs_n` low and `rw_ctl` high (read), the latched register is driven on `data_o` with `data_oe` high.
- R7: In Motorola-style mode, an access with `rw_ctl` low (write) stores `data_i` into the latched address when the synchronized data strobe deasserts.
- R8: In synchronous mode, a rising edge that samples `cs_n`, `strb_n` (write enable) and `rw_ctl` all low stores `data_i` into `addr_i` on that same edge. `ale_as` is ignored. `strb_n` low with `rw_ctl` high writes nothing.
- R9: In synchronous mode, an edge that samples `cs_n` low and `rw_ctl` high drives the register at that address on `data_o`, with `data_oe` high, in the following cycle.
- R10: `data_oe` is never high while `cs_n` is high. A read strobe with `cs_n` high leaves `data_oe` low.
- R11: Register index is `addr_i[3:0]` with 16 registers. An address with any of bits 14:4 set reads as 0, and a write to it changes no register.
- R12: Reset clears every register to 0 and holds `data_oe` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the processor clock in synchronous mode |
| rst_n | input | 1 | Active-low reset; mode is sampled while low |
| mode_sel | input | 2 | Bus style select |
| cs_n | input | 1 | Active-low chip select |
| addr_i | input | 15 | Host address bus |
| ale_as | input | 1 | Address latch (Intel, high) / address strobe (Motorola, low) / unused (sync) |
| strb_n | input | 1 | Read strobe / data strobe / write enable, all active low |
| rw_ctl | input | 1 | Write strobe (Intel, low) / direction, high = read (Motorola and sync) |
| data_i | input | 8 | Data bus input from the pad |
| data_o | output | 8 | Data bus output to the pad |
| data_oe | output | 1 | Data bus output enable; low = high impedance |

## Verification
The bench runs all three modes and checks at the ports after each access.

- **Mode changed after reset.** The bench flips `mode_sel` after reset and keeps issuing synchronous writes. A design that tracked the pin would stop accepting those writes.
- **Ignored pins in synchronous mode.** It toggles `ale_as` and holds `strb_n` low with the direction set to read. A design that latched addresses or wrote in either case would corrupt the registers the bench reads back.
- **Chip select and unmapped addresses.** A read strobe with chip select high must leave the bus undriven. A write above the 16-register window must neither appear at its aliased low index nor read back as anything but zero.
- **Strobe edge choice.** Motorola writes must store on data-strobe release and Intel writes on write-strobe release. A wrong edge shows up as stale or missing data on the following read.

// File: rtl/hbi_pkg.sv
`timescale 1ns/1ps
package hbi_pkg;
  typedef enum logic [1:0] {
    BUS_INTEL = 2'b00,
    BUS_MOTO  = 2'b01,
    BUS_SYNC  = 2'b10
  } bus_mode_e;

  // Bit positions in the synchronized control vector.
  localparam int unsigned SIG_CS   = 0;
  localparam int unsigned SIG_STRB = 1;
  localparam int unsigned SIG_ALE  = 2;
  localparam int unsigned SIG_WRL  = 3;
  localparam int unsigned SIG_N    = 4;

  function automatic bus_mode_e decode_mode(input logic [1:0] sel);
    if (sel[1])      return BUS_SYNC;
    else if (sel[0]) return BUS_MOTO;
    else             return BUS_INTEL;
  endfunction
endpackage

// File: rtl/hbi_sync.sv
`timescale 1ns/1ps
module hbi_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbi_decode.sv
`timescale 1ns/1ps
module hbi_decode
  import hbi_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_mode_e         mode,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ale_as,
  input  logic              strb_n,
  input  logic              rw_ctl,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [SIG_N-1:0] raw_act, s_cur, s_prev;
  logic             ale_fall, strb_fall, wrl_fall;
  logic             intel_arm_q, moto_arm_q, sync_rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic             async_wr, async_rd;

  // Normalise every control to active high before synchronizing, so all
  // flops reset to the idle value 0 whatever the mode.
  always_comb begin
    raw_act           = '0;
    raw_act[SIG_CS]   = ~cs_n;
    raw_act[SIG_STRB] = ~strb_n;
    raw_act[SIG_ALE]  = (mode == BUS_MOTO) ? ~ale_as : ale_as;
    raw_act[SIG_WRL]  = ~rw_ctl;
  end

  hbi_sync #(.WIDTH(SIG_N), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_act),
    .q_o   (s_cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_prev      <= '0;
      intel_arm_q <= 1'b0;
      moto_arm_q  <= 1'b0;
      sync_rd_q   <= 1'b0;
    end else begin
      s_prev      <= s_cur;
      intel_arm_q <= s_cur[SIG_WRL] & s_cur[SIG_CS];
      moto_arm_q  <= s_cur[SIG_STRB] & s_cur[SIG_WRL] & s_cur[SIG_CS];
      sync_rd_q   <= (mode == BUS_SYNC) & ~cs_n & rw_ctl;
    end
  end

  assign ale_fall  = s_prev[SIG_ALE]  & ~s_cur[SIG_ALE];
  assign strb_fall = s_prev[SIG_STRB] & ~s_cur[SIG_STRB];
  assign wrl_fall  = s_prev[SIG_WRL]  & ~s_cur[SIG_WRL];

  // Address register: latch edge in async modes, every selected cycle in sync mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (mode == BUS_SYNC) begin
      if (!cs_n) addr_q <= addr_i;
    end else if (ale_fall) addr_q <= addr_i;
  end

  always_comb begin
    async_wr = 1'b0;
    async_rd = 1'b0;
    unique case (mode)
      BUS_INTEL: begin
        async_wr = wrl_fall & intel_arm_q;
        async_rd = s_cur[SIG_STRB] & s_cur[SIG_CS];
      end
      BUS_MOTO: begin
        async_wr = strb_fall & moto_arm_q;
        async_rd = s_cur[SIG_STRB] & s_cur[SIG_CS] & ~s_cur[SIG_WRL];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (mode == BUS_SYNC) begin
      wr_en   = ~cs_n & ~strb_n & ~rw_ctl;
      wr_addr = addr_i;
    end else begin
      wr_en   = async_wr;
      wr_addr = addr_q;
    end
  end

  assign wr_data = data_i;
  assign rd_addr = addr_q;
  // Raw chip select gates the bus driver so a late synchronizer cannot hold it on.
  assign rd_en   = ~cs_n & ((mode == BUS_SYNC) ? sync_rd_q : async_rd);

  // R2 R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != BUS_SYNC && !ale_fall) |=> $stable(addr_q));

  // R8
  sync_wr_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BUS_SYNC && wr_en) |-> (!cs_n && !strb_n));
endmodule

// File: rtl/hbi_regs.sv
`timescale 1ns/1ps
module hbi_regs #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_hit, rd_hit;

  assign wr_idx = wr_addr[IDX_W-1:0];
  assign rd_idx = rd_addr[IDX_W-1:0];
  assign wr_hit = (wr_addr[ADDR_W-1:IDX_W] == '0) && (int'(wr_idx) < DEPTH);
  assign rd_hit = (rd_addr[ADDR_W-1:IDX_W] == '0) && (int'(rd_idx) < DEPTH);

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '0;
      else if (wr_en && wr_hit && (int'(wr_idx) == i)) mem[i] <= wr_data;
    end
  end

  assign rd_data = rd_hit ? mem[rd_idx] : '0;

  // R4 R7 R8
  write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit) |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/host_bus_slave.sv
`timescale 1ns/1ps
module host_bus_slave
  import hbi_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ale_as,
  input  logic              strb_n,
  input  logic              rw_ctl,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe
);
  bus_mode_e         mode_q;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  // Mode is loaded only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= decode_mode(mode_sel);
  end

  hbi_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .cs_n    (cs_n),
    .addr_i  (addr_i),
    .ale_as  (ale_as),
    .strb_n  (strb_n),
    .rw_ctl  (rw_ctl),
    .data_i  (data_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr)
  );

  hbi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign data_oe = rd_en & rst_n;
  assign data_o  = data_oe ? rd_data : '0;

  // R10
  oe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !cs_n);

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: tb/sim_host_bus_slave.sv
`timescale 1ns/1ps
module sim_host_bus_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b10;
  logic        cs_n = 1'b1;
  logic [14:0] addr_i = '0;
  logic        ale_as = 1'b0;
  logic        strb_n = 1'b1;
  logic        rw_ctl = 1'b1;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic        data_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_on = 0;
  logic [14:0] mon_addr = '0;
  int model [16];

  always #2 clk = ~clk;

  host_bus_slave u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
    .addr_i(addr_i), .ale_as(ale_as), .strb_n(strb_n), .rw_ctl(rw_ctl),
    .data_i(data_i), .data_o(data_o), .data_oe(data_oe)
  );

  function automatic int model_rd(input logic [14:0] a);
    if (a[14:4] != 0) return 0;
    return model[a[3:0]];
  endfunction

  function automatic void model_wr(input logic [14:0] a, input int d);
    if (a[14:4] == 0) model[a[3:0]] = d;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Every-clock comparison against the behavioural model while driving.
  always @(negedge clk) begin
    if (rst_n && mon_on && data_oe) begin
      chk("R10 oe with cs_n", int'(cs_n), 0);
      chk("R3/R6/R9 bus data", int'(data_o), model_rd(mon_addr));
    end
  end

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0;
    mode_sel = m;
    cs_n = 1'b1; strb_n = 1'b1; rw_ctl = 1'b1;
    ale_as = (m == 2'b01) ? 1'b1 : 1'b0;
    for (int i = 0; i < 16; i++) model[i] = 0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    @(negedge clk);
    chk("R12 oe after reset", int'(data_oe), 0);
    tick(1);
  endtask

  task automatic sync_wr(input logic [14:0] a, input logic [7:0] d, input logic ale);
    cs_n = 0; strb_n = 0; rw_ctl = 0; addr_i = a; data_i = d; ale_as = ale;
    tick(1);
    cs_n = 1; strb_n = 1; rw_ctl = 1; ale_as = ~ale;
    model_wr(a, int'(d));
    tick(1);
  endtask

  task automatic sync_rd(input logic [14:0] a, input string req);
    mon_addr = a;
    cs_n = 0; rw_ctl = 1; addr_i = a;
    tick(1);
    @(negedge clk);
    chk({req, " oe"}, int'(data_oe), 1);
    chk({req, " data"}, int'(data_o), model_rd(a));
    tick(1);
    cs_n = 1;
    tick(1);
  endtask

  task automatic intel_wr(input logic [14:0] a, input logic [7:0] d);
    cs_n = 0; addr_i = a; ale_as = 1; tick(4);
    ale_as = 0; tick(4);
    data_i = d; rw_ctl = 0; tick(4);
    rw_ctl = 1; tick(4);
    cs_n = 1; model_wr(a, int'(d)); tick(2);
  endtask

  task automatic intel_rd(input logic [14:0] a, input logic sel_n, input string req);
    mon_addr = a;
    cs_n = sel_n; addr_i = a; ale_as = 1; tick(4);
    ale_as = 0; tick(4);
    strb_n = 0; tick(5);
    @(negedge clk);
    chk({req, " oe"}, int'(data_oe), sel_n ? 0 : 1);
    if (!sel_n) chk({req, " data"}, int'(data_o), model_rd(a));
    tick(1);
    strb_n = 1; tick(4);
    @(negedge clk);
    chk({req, " oe release"}, int'(data_oe), 0);
    tick(1);
    cs_n = 1; tick(2);
  endtask

  task automatic moto_wr(input logic [14:0] a, input logic [7:0] d);
    cs_n = 0; addr_i = a; ale_as = 0; tick(4);
    ale_as = 1; tick(4);
    rw_ctl = 0; data_i = d; strb_n = 0; tick(4);
    strb_n = 1; tick(4);
    rw_ctl = 1; cs_n = 1; model_wr(a, int'(d)); tick(2);
  endtask

  task automatic moto_rd(input logic [14:0] a, input string req);
    mon_addr = a;
    cs_n = 0; rw_ctl = 1; addr_i = a; ale_as = 0; tick(4);
    ale_as = 1; tick(4);
    strb_n = 0; tick(5);
    @(negedge clk);
    chk({req, " oe"}, int'(data_oe), 1);
    chk({req, " data"}, int'(data_o), model_rd(a));
    tick(1);
    strb_n = 1; tick(4);
    @(negedge clk);
    chk({req, " oe release"}, int'(data_oe), 0);
    tick(1);
    cs_n = 1; tick(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    mon_on = 1;
    // Synchronous mode.
    do_reset(2'b10);
    sync_rd(15'd3, "R12 cleared reg");
    sync_wr(15'd3, 8'hA5, 1'b0);
    sync_wr(15'd5, 8'h3C, 1'b1);
    sync_rd(15'd3, "R8 R9 reg3");
    sync_rd(15'd5, "R8 R9 reg5");
    mode_sel = 2'b00;                       // R1: must be ignored
    sync_wr(15'd7, 8'h11, 1'b1);
    sync_rd(15'd7, "R1 mode held");
    sync_wr(15'd2, 8'h77, 1'b1);            // R8: ale_as toggling ignored
    sync_wr(15'd2, 8'h78, 1'b0);
    sync_rd(15'd2, "R8 ale ignored");
    cs_n = 0; strb_n = 0; rw_ctl = 1; addr_i = 15'd3; data_i = 8'hFF; tick(1);
    cs_n = 1; strb_n = 1; tick(1);
    sync_rd(15'd3, "R8 we with read dir");
    cs_n = 1; strb_n = 0; rw_ctl = 0; addr_i = 15'd5; data_i = 8'hEE; tick(1);
    strb_n = 1; rw_ctl = 1; tick(1);
    sync_rd(15'd5, "R10 write without cs");

    // Encoding 11 is synchronous too.
    do_reset(2'b11);
    sync_wr(15'd9, 8'h5F, 1'b0);
    sync_rd(15'd9, "R1 code 11 sync");

    // Intel-style mode.
    do_reset(2'b00);
    intel_rd(15'd4, 1'b0, "R12 R3 cleared");
    intel_wr(15'd4, 8'h5A);
    intel_wr(15'd9, 8'hC3);
    intel_rd(15'd4, 1'b0, "R2 R3 R4 reg4");
    intel_rd(15'd9, 1'b0, "R2 R3 R4 reg9");
    intel_rd(15'd9, 1'b1, "R10 read no cs");
    intel_wr(15'h4001, 8'hEE);
    intel_rd(15'h4001, 1'b0, "R11 unmapped");
    intel_rd(15'd1, 1'b0, "R11 alias untouched");

    // Motorola-style mode.
    do_reset(2'b01);
    moto_wr(15'd2, 8'h99);
    moto_wr(15'd15, 8'h42);
    moto_rd(15'd2, "R5 R6 R7 reg2");
    moto_rd(15'd15, "R5 R6 R7 reg15");
    moto_wr(15'd2, 8'h18);
    moto_rd(15'd2, "R7 overwrite");
    moto_rd(15'd0, "R12 R6 untouched");

    mon_on = 0;
    tick(4);
    finish_run();
  end
endmodule